// File: doc/BRIEF.md
# Precision Time Hardware Assist

This block keeps a 64-bit system time that grows by a programmable 32-bit step on every clock edge. The carry out of the low word feeds the high word. Firmware programs the step, a 32-bit target value, and a 6-bit bit selector through a small word-addressed register port. Firmware can also load a full 64-bit time. The low half is staged first, and the whole value takes effect in one cycle when the high half is written.

When the low word of time equals the target value, a pulse-per-second output goes high. It stays high until firmware clears it. Two external event inputs, one for slave-side events and one for master-side events, each go through a synchronizer. Each has its own capture register, and on a rising edge of the synchronized input that register latches the current time. A channel that holds a capture is locked against further captures until firmware reads its high word. A debug pin copies whichever time bit the selector names.

Register map (word addresses on `reg_addr`): 0 time low, 1 time high, 2 step, 3 target, 4 bit selector, 5 status/clear, 6 slave capture low, 7 slave capture high, 8 master capture low, 9 master capture high. Any other address reads zero. `reg_rdata` is combinational from `reg_addr`. A write or a read side effect takes place at the clock edge where `reg_wr` or `reg_rd` is high.

Top module: `ptp_assist`

## Requirements
- R1: On every clock edge with no time load, time becomes old time plus the zero-extended 32-bit step, modulo 2^64. A carry out of bit 31 increments the high word.
- R2: A write to address 0 only stages a value and does not change time. A write to address 1 sets time to {written high word, staged low word} at that edge. Reads of addresses 0 and 1 return the live low and high words.
- R3: When the low word of time equals the target (address 3), `pps_out` is high from the next clock edge.
- R4: Once high, `pps_out` stays high until a write to address 5 with bit 0 set. After such a write, with no match present, it is low from that edge on. Status bit 0 reads the same level.
- R5: If a match and a clear occur in the same cycle, the match wins and `pps_out` stays high.
- R6: `test_out` equals time bit [sel], where sel is the 6-bit value written to address 4 (sel = 0 is the least significant bit).
- R7: A low-to-high transition on `snap_slave` latches the current time into the slave capture (addresses 6/7) within 4 cycles and sets status bit 1. A level held high causes no further capture.
- R8: While a channel's capture flag is set, further edges on that channel are ignored. A read of the channel's high word (address 7 or 9) clears the flag.
- R9: `snap_master` behaves in the same way, with its own capture (addresses 8/9) and status bit 2. It is independent of the slave channel.
- R10: After reset, time starts at 0 with a step of 1, the target is all ones, the selector is 0, both captures and all status bits are 0, and `pps_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (for read side effects) |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| snap_slave | input | 1 | Asynchronous slave-side event input |
| snap_master | input | 1 | Asynchronous master-side event input |
| pps_out | output | 1 | Sticky target-match output |
| test_out | output | 1 | Selected time bit |

## Verification
The counter is tried with a table of start value and step pairs. One pair has no carry, one carries across the word boundary, one wraps all 64 bits to zero, and one uses a large step that crosses the boundary exactly. Together they separate a correct carry from a truncated one. The target output is driven by time sweeping through the target, by time moving past it before a clear, and by time frozen on the target during a clear, which tells a sticky flag apart from a level compare and shows which of clear and match has priority. The event inputs are tried with a held level, with a re-edge while locked, with a re-edge after unlock, and with activity on the other channel, so that edge detection, locking and channel independence are each shown on their own.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
  typedef enum logic [3:0] {
    A_TIME_LO = 4'd0,
    A_TIME_HI = 4'd1,
    A_STEP    = 4'd2,
    A_TARGET  = 4'd3,
    A_SEL     = 4'd4,
    A_STATUS  = 4'd5,
    A_SLV_LO  = 4'd6,
    A_SLV_HI  = 4'd7,
    A_MST_LO  = 4'd8,
    A_MST_HI  = 4'd9
  } ptp_addr_e;

  localparam int unsigned ST_PPS = 0;
  localparam int unsigned ST_SLV = 1;
  localparam int unsigned ST_MST = 2;
  localparam int unsigned N_CHAN = 2;
  localparam int unsigned CH_SLV = 0;
  localparam int unsigned CH_MST = 1;
endpackage

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int unsigned DW      = 32,
  parameter int unsigned STEP_RST = 1,
  localparam int unsigned TW     = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_wr,
  input  logic          lo_wr,
  input  logic          hi_wr,
  input  logic [DW-1:0] wdata,
  output logic [TW-1:0] time_o,
  output logic [DW-1:0] step_o,
  output logic          commit_o
);
  logic [TW-1:0] time_q;
  logic [DW-1:0] step_q;
  logic [DW-1:0] stage_q;

  function automatic logic [TW-1:0] advance(input logic [TW-1:0] t,
                                            input logic [DW-1:0] s);
    return t + {{DW{1'b0}}, s};
  endfunction

  assign commit_o = hi_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q  <= '0;
      step_q  <= DW'(STEP_RST);
      stage_q <= '0;
    end else begin
      if (step_wr) step_q <= wdata;
      if (lo_wr)   stage_q <= wdata;
      if (hi_wr)   time_q <= {wdata, stage_q};
      else         time_q <= advance(time_q, step_q);
    end
  end

  assign time_o = time_q;
  assign step_o = step_q;
endmodule

// File: rtl/ptp_pps_compare.sv
module ptp_pps_compare #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tgt_wr,
  input  logic          clr_req,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] time_lo,
  output logic [DW-1:0] tgt_o,
  output logic          match_o,
  output logic          pps_o
);
  logic [DW-1:0] tgt_q;
  logic          pps_q;

  function automatic logic next_flag(input logic cur, input logic hit,
                                     input logic clr);
    return hit | (cur & ~clr);
  endfunction

  assign match_o = (time_lo == tgt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '1;
      pps_q <= 1'b0;
    end else begin
      if (tgt_wr) tgt_q <= wdata;
      pps_q <= next_flag(pps_q, match_o, clr_req);
    end
  end

  assign tgt_o = tgt_q;
  assign pps_o = pps_q;
endmodule

// File: rtl/ptp_snap_channel.sv
module ptp_snap_channel #(
  parameter int unsigned TW          = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snap_in,
  input  logic [TW-1:0] time_i,
  input  logic          unlock,
  output logic [TW-1:0] snap_o,
  output logic          valid_o,
  output logic          capture_o
);
  logic [SYNC_STAGES:0] sh_q;
  logic [TW-1:0]        snap_q;
  logic                 valid_q;
  logic                 rise;

  assign rise      = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign capture_o = rise & ~valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      snap_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sh_q <= {sh_q[SYNC_STAGES-1:0], snap_in};
      if (capture_o) begin
        snap_q  <= time_i;
        valid_q <= 1'b1;
      end else if (unlock) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign snap_o  = snap_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/ptp_assist.sv
module ptp_assist #(
  parameter int unsigned DW          = 32,
  parameter int unsigned STEP_RST    = 1,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TW         = 2 * DW,
  localparam int unsigned SW         = $clog2(TW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          snap_slave,
  input  logic          snap_master,
  output logic          pps_out,
  output logic          test_out
);
  import ptp_pkg::*;

  logic [TW-1:0] time_q;
  logic [DW-1:0] step_q;
  logic [DW-1:0] tgt_q;
  logic          time_commit;
  logic          cmp_match;
  logic          pps_clr;
  logic          pps;
  logic [SW-1:0] sel_q;

  logic [N_CHAN-1:0]         chan_in;
  logic [N_CHAN-1:0]         chan_unlock;
  logic [N_CHAN-1:0]         chan_valid;
  logic [N_CHAN-1:0]         chan_capture;
  logic [N_CHAN-1:0][TW-1:0] chan_snap;

  logic wr_lo, wr_hi, wr_step, wr_tgt, wr_sel;

  assign wr_lo   = reg_wr && (reg_addr == A_TIME_LO);
  assign wr_hi   = reg_wr && (reg_addr == A_TIME_HI);
  assign wr_step = reg_wr && (reg_addr == A_STEP);
  assign wr_tgt  = reg_wr && (reg_addr == A_TARGET);
  assign wr_sel  = reg_wr && (reg_addr == A_SEL);
  assign pps_clr = reg_wr && (reg_addr == A_STATUS) && reg_wdata[ST_PPS];

  assign chan_in[CH_SLV]     = snap_slave;
  assign chan_in[CH_MST]     = snap_master;
  assign chan_unlock[CH_SLV] = reg_rd && (reg_addr == A_SLV_HI);
  assign chan_unlock[CH_MST] = reg_rd && (reg_addr == A_MST_HI);

  ptp_time_counter #(.DW(DW), .STEP_RST(STEP_RST)) u_time (
    .clk(clk), .rst_n(rst_n), .step_wr(wr_step), .lo_wr(wr_lo),
    .hi_wr(wr_hi), .wdata(reg_wdata), .time_o(time_q), .step_o(step_q),
    .commit_o(time_commit)
  );

  ptp_pps_compare #(.DW(DW)) u_pps (
    .clk(clk), .rst_n(rst_n), .tgt_wr(wr_tgt), .clr_req(pps_clr),
    .wdata(reg_wdata), .time_lo(time_q[DW-1:0]), .tgt_o(tgt_q),
    .match_o(cmp_match), .pps_o(pps)
  );

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    ptp_snap_channel #(.TW(TW), .SYNC_STAGES(SYNC_STAGES)) u_snap (
      .clk(clk), .rst_n(rst_n), .snap_in(chan_in[c]), .time_i(time_q),
      .unlock(chan_unlock[c]), .snap_o(chan_snap[c]),
      .valid_o(chan_valid[c]), .capture_o(chan_capture[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (wr_sel) sel_q <= reg_wdata[SW-1:0];
  end

  assign test_out = time_q[sel_q];
  assign pps_out  = pps;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_TIME_LO: reg_rdata = time_q[DW-1:0];
      A_TIME_HI: reg_rdata = time_q[TW-1:DW];
      A_STEP:    reg_rdata = step_q;
      A_TARGET:  reg_rdata = tgt_q;
      A_SEL:     reg_rdata = DW'(sel_q);
      A_STATUS: begin
        reg_rdata[ST_PPS] = pps;
        reg_rdata[ST_SLV] = chan_valid[CH_SLV];
        reg_rdata[ST_MST] = chan_valid[CH_MST];
      end
      A_SLV_LO:  reg_rdata = chan_snap[CH_SLV][DW-1:0];
      A_SLV_HI:  reg_rdata = chan_snap[CH_SLV][TW-1:DW];
      A_MST_LO:  reg_rdata = chan_snap[CH_MST][DW-1:0];
      A_MST_HI:  reg_rdata = chan_snap[CH_MST][TW-1:DW];
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ptp_assist_checker.sv
module ptp_assist_checker #(
  parameter int unsigned DW = 32,
  localparam int unsigned TW = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] time_q,
  input logic [DW-1:0] step_q,
  input logic          time_commit,
  input logic          cmp_match,
  input logic          pps_clr,
  input logic          pps,
  input logic [1:0]    chan_valid,
  input logic [1:0]    chan_capture,
  input logic [TW-1:0] snap_slv,
  input logic [TW-1:0] snap_mst
);
  assert_time_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !time_commit |=> time_q == $past(time_q) + {{DW{1'b0}}, $past(step_q)});

  assert_pps_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_match |=> pps);

  assert_pps_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pps && !pps_clr |=> pps);

  assert_pps_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pps) |-> $past(pps_clr));

  assert_slv_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_valid[0] |=> $stable(snap_slv));

  assert_mst_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chan_valid[1] |=> $stable(snap_mst));

  assert_slv_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chan_capture[0] |=> chan_valid[0] && snap_slv == $past(time_q));

  assert_no_capture_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_valid[1] |-> !chan_capture[1]);
endmodule

bind ptp_assist ptp_assist_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .time_q(time_q), .step_q(step_q),
  .time_commit(time_commit), .cmp_match(cmp_match), .pps_clr(pps_clr),
  .pps(pps), .chan_valid(chan_valid), .chan_capture(chan_capture),
  .snap_slv(chan_snap[0]), .snap_mst(chan_snap[1])
);

// File: tb/ptp_assist_bench.sv
`timescale 1ns/1ps
module ptp_assist_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        snap_slave = 1'b0;
  logic        snap_master = 1'b0;
  logic        pps_out;
  logic        test_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ptp_assist u_ptp_assist (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .snap_slave(snap_slave), .snap_master(snap_master),
    .pps_out(pps_out), .test_out(test_out)
  );

  localparam int NV = 5;
  localparam logic [63:0] V_START [NV] = '{
    64'h00000000_00000010, 64'h00000001_FFFFFFFE, 64'hFFFFFFFF_FFFFFFFF,
    64'h12345678_9ABCDEF0, 64'h0000000A_80000000};
  localparam logic [31:0] V_STEP [NV] = '{
    32'h3, 32'h5, 32'h1, 32'h10, 32'h80000000};
  localparam logic [63:0] V_EXP [NV] = '{
    64'h00000000_00000013, 64'h00000002_00000003, 64'h00000000_00000000,
    64'h12345678_9ABCDF00, 64'h0000000B_00000000};

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_time(input logic [63:0] t);
    wr(4'd2, 32'h0);
    wr(4'd0, t[31:0]);
    wr(4'd1, t[63:32]);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R10 reset state
    chk("R10 pps", {63'b0, pps_out}, 64'd0);
    rd(4'd5, d);  chk("R10 status", {32'b0, d}, 64'd0);
    rd(4'd3, d);  chk("R10 target", {32'b0, d}, 64'hFFFFFFFF);
    rd(4'd2, d);  chk("R10 step", {32'b0, d}, 64'd1);
    rd(4'd4, d);  chk("R10 sel", {32'b0, d}, 64'd0);
    rd(4'd6, d);  chk("R10 slave capture", {32'b0, d}, 64'd0);
    rd(4'd1, d);  chk("R10 time high", {32'b0, d}, 64'd0);
    // R1 free running with step 1: reads 10 cycles apart differ by 10
    rd(4'd0, d);
    idle(9);
    rd(4'd0, d2);
    chk("R1 reset step count", {32'b0, d2 - d}, 64'd10);

    // R1/R2 vector table: load, advance one edge, freeze, read back
    for (int i = 0; i < NV; i++) begin
      wr(4'd2, V_STEP[i]);
      wr(4'd0, V_START[i][31:0]);
      wr(4'd1, V_START[i][63:32]);
      wr(4'd2, 32'h0);
      rd(4'd0, d);
      rd(4'd1, d2);
      chk("R1 advance/carry", {d2, d}, V_EXP[i]);
    end

    // R2 low write alone is only staged
    set_time(64'h00000005_00000006);
    wr(4'd0, 32'hAAAA5555);
    rd(4'd0, d);
    chk("R2 staged low not applied", {32'b0, d}, 64'h6);
    wr(4'd1, 32'h77);
    rd(4'd0, d); rd(4'd1, d2);
    chk("R2 commit", {d2, d}, 64'h00000077_AAAA5555);

    // R3/R4 sweep through target
    wr(4'd3, 32'h100);
    set_time(64'h0000_0000_0000_00FD);
    wr(4'd5, 32'h1);
    chk("R4 cleared before sweep", {63'b0, pps_out}, 64'd0);
    wr(4'd2, 32'h1);
    idle(8);
    chk("R3 match sets pps", {63'b0, pps_out}, 64'd1);
    idle(5);
    chk("R4 sticky after time passes", {63'b0, pps_out}, 64'd1);
    rd(4'd5, d);
    chk("R4 status bit0", {63'b0, d[0]}, 64'd1);
    wr(4'd5, 32'h1);
    chk("R4 clear", {63'b0, pps_out}, 64'd0);
    wr(4'd5, 32'h0);
    chk("R4 write without bit0", {63'b0, pps_out}, 64'd0);

    // R5 clear during match
    set_time(64'h0000_0000_0000_0100);
    idle(2);
    wr(4'd5, 32'h1);
    chk("R5 match beats clear", {63'b0, pps_out}, 64'd1);
    wr(4'd3, 32'h0);
    wr(4'd5, 32'h1);

    // R6 test bit select
    set_time(64'h80000000_00000001);
    wr(4'd4, 32'd0);  chk("R6 sel 0", {63'b0, test_out}, 64'd1);
    wr(4'd4, 32'd1);  chk("R6 sel 1", {63'b0, test_out}, 64'd0);
    wr(4'd4, 32'd63); chk("R6 sel 63", {63'b0, test_out}, 64'd1);
    wr(4'd4, 32'd32); chk("R6 sel 32", {63'b0, test_out}, 64'd0);

    // R7 slave capture on edge
    set_time(64'h00000011_00000022);
    snap_slave = 1'b1;
    idle(5);
    rd(4'd5, d);
    chk("R7 slave flag", {32'b0, d & 32'h6}, 64'h2);
    set_time(64'h00000033_00000044);
    idle(5);
    rd(4'd6, d);
    chk("R7 held level no recapture", {32'b0, d}, 64'h22);
    rd(4'd7, d);
    chk("R7 slave high word", {32'b0, d}, 64'h11);
    rd(4'd5, d);
    chk("R8 high read unlocks", {32'b0, d & 32'h6}, 64'h0);
    set_time(64'h00000055_00000066);
    idle(5);
    rd(4'd5, d);
    chk("R7 held level after unlock", {32'b0, d & 32'h6}, 64'h0);
    snap_slave = 1'b0;
    idle(4);
    snap_slave = 1'b1;
    idle(5);
    rd(4'd6, d);
    chk("R7 new edge captures", {32'b0, d}, 64'h66);
    // R8 locked channel ignores edge
    set_time(64'h00000077_00000088);
    snap_slave = 1'b0;
    idle(4);
    snap_slave = 1'b1;
    idle(5);
    rd(4'd6, d);
    chk("R8 locked ignores edge", {32'b0, d}, 64'h66);
    rd(4'd5, d);
    chk("R9 master flag untouched", {63'b0, d[2]}, 64'd0);

    // R9 master channel
    snap_master = 1'b1;
    idle(5);
    rd(4'd5, d);
    chk("R9 master flag", {32'b0, d & 32'h6}, 64'h6);
    rd(4'd8, d); rd(4'd9, d2);
    chk("R9 master capture", {d2, d}, 64'h00000077_00000088);
    rd(4'd5, d);
    chk("R9 master unlock keeps slave", {32'b0, d & 32'h6}, 64'h2);
    rd(4'd6, d);
    chk("R9 slave capture unchanged", {32'b0, d}, 64'h66);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule